// File: doc/BRIEF.md
# Prioritized Nested Interrupt Sequencer

This block sits next to a small processor core and decides when the core takes an interrupt. Three request lines carry fixed priorities, and line 3 is the most urgent. The block holds a current mask level. At an instruction boundary it takes the most urgent request whose level is strictly above that mask. It then raises the mask to the level it has taken and saves the level it interrupted on a four-entry internal stack.

After a take, the core fetches the vector for that level and hands it back. The block decides whether the word is a task number or a handler address. It records that choice in the stack entry it has just pushed. A later return-from-interrupt pops the entry. It restores the saved level and reports whether the core must resume a task or make an ordinary return.

The core decodes mask-set, mask-clear and return instructions and sends each to the block as a single-cycle strobe. A mask-set may carry its own level. A mask-clear takes effect only after a fixed delay, so a request that stays asserted cannot pin the core on one instruction. Misuse of the stack raises sticky error flags.

Top module: `irq_nest_seq`

## Requirements
- R1: When several request lines are eligible, the take reports the highest one. Line bit i of `irq_line` stands for level i+1, so `take_lvl` reads 1, 2 or 3.
- R2: A take happens only when the highest asserted level is strictly greater than `cur_lvl`. A line at or below the current level causes no take and stays ignored until the level drops.
- R3: The sequencer samples requests only at an edge where `insn_end` is high, no `sei_op`, `cli_op` or `rti_op` strobe is present, and no vector is outstanding. On the following cycle `take_irq` is high for exactly one cycle, and `cur_lvl` equals `take_lvl`.
- R4: Each take pushes the level it interrupted. An `rti_op` pops the newest entry, restores that level to `cur_lvl` on the next cycle, and pulses `rti_done` for one cycle.
- R5: After a take, `vec_ok` delivers `vec_in`, and `vec_done` pulses on the next cycle. If bits 15:9 are all zero, `vec_is_task` is 1 and `vec_task_no` equals bits 8:0. Otherwise `vec_is_task` is 0.
- R6: `rti_task` on a pop equals the classification recorded for that same entry, taken in last-in first-out order across nested interrupts.
- R7: `sei_op` with `sei_has_lvl`=1 sets `cur_lvl` to `sei_lvl` on the next cycle. With `sei_has_lvl`=0 it sets `cur_lvl` to 3. A mask-set also cancels a mask-clear that is still waiting.
- R8: After `cli_op` is sampled at an edge, `cur_lvl` keeps its old value after that edge and the next two edges, and reads 0 after the third. A take during that window pushes 0 as the interrupted level.
- R9: `rti_op` with an empty stack changes nothing: there is no `rti_done` and `cur_lvl` is unchanged. It sets `err_under`, which stays set until reset.
- R10: A take while four entries are held still pulses `take_irq`, but nothing is pushed, and `err_over` is set and stays set until reset. Afterwards only four returns succeed.
- R11: Reset empties the stack, sets `cur_lvl` to 0, and clears both error flags, the mask-clear delay and any outstanding vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | 3 | Request lines; bit i is level i+1 |
| insn_end | input | 1 | Instruction boundary strobe |
| sei_op | input | 1 | Mask-set instruction strobe |
| sei_has_lvl | input | 1 | Mask-set carries a level operand |
| sei_lvl | input | 2 | Mask-set level operand |
| cli_op | input | 1 | Mask-clear instruction strobe |
| rti_op | input | 1 | Return-from-interrupt strobe |
| vec_ok | input | 1 | Fetched vector is valid |
| vec_in | input | 16 | Fetched vector word |
| take_irq | output | 1 | One-cycle take pulse |
| take_lvl | output | 2 | Level of the take |
| vec_done | output | 1 | Vector classified pulse |
| vec_is_task | output | 1 | Vector is a task number |
| vec_task_no | output | 9 | Task number from the vector |
| rti_done | output | 1 | Return popped an entry |
| rti_task | output | 1 | Popped entry entered by task switch |
| cur_lvl | output | 2 | Current mask level |
| err_under | output | 1 | Sticky stack underflow |
| err_over | output | 1 | Sticky stack overflow |

## Verification
The take decision is swept over every combination of the four mask levels and the eight request patterns. This separates strict-greater preemption from at-or-below blocking and checks that the most urgent line wins. Vectors with a single bit set in each position, plus all-zero and all-one words, separate the task range from the address range at the bit 9 boundary, and each result is followed by a pop to confirm the recorded bit. A three-deep nest with mixed vector kinds checks last-in first-out restore. A timed mask-clear with a request held above it separates the delayed release from an immediate one. A forced re-nest five times deep drives both the overflow and the underflow paths.

// File: rtl/irq_nest_seq.sv
module irq_nest_seq #(
  parameter int LEVELS     = 3,
  parameter int VEC_W      = 16,
  parameter int TASK_TAG_W = 7,
  parameter int STK_DEPTH  = 4,
  parameter int CLI_DELAY  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [LEVELS-1:0]               irq_line,
  input  logic                            insn_end,
  input  logic                            sei_op,
  input  logic                            sei_has_lvl,
  input  logic [$clog2(LEVELS+1)-1:0]     sei_lvl,
  input  logic                            cli_op,
  input  logic                            rti_op,
  input  logic                            vec_ok,
  input  logic [VEC_W-1:0]                vec_in,
  output logic                            take_irq,
  output logic [$clog2(LEVELS+1)-1:0]     take_lvl,
  output logic                            vec_done,
  output logic                            vec_is_task,
  output logic [VEC_W-TASK_TAG_W-1:0]     vec_task_no,
  output logic                            rti_done,
  output logic                            rti_task,
  output logic [$clog2(LEVELS+1)-1:0]     cur_lvl,
  output logic                            err_under,
  output logic                            err_over
);

  localparam int LVL_W  = $clog2(LEVELS+1);
  localparam int TASK_W = VEC_W - TASK_TAG_W;
  localparam int CNT_W  = $clog2(STK_DEPTH+1);
  localparam int PTR_W  = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;
  localparam int DLY_W  = $clog2(CLI_DELAY+1);

  logic [LVL_W-1:0] stk_lvl [STK_DEPTH];
  logic             stk_tsk [STK_DEPTH];
  logic [CNT_W-1:0] depth_q;
  logic [DLY_W-1:0] cli_cnt;
  logic             vec_wait;
  logic             pushed_q;
  logic [LVL_W-1:0] hi_lvl;

  always_comb begin
    hi_lvl = '0;
    for (int i = 0; i < LEVELS; i++)
      if (irq_line[i]) hi_lvl = LVL_W'(i + 1);
  end

  wire              any_strobe = sei_op | cli_op | rti_op;
  wire              can_take   = insn_end && !any_strobe && !vec_wait && (hi_lvl > cur_lvl);
  wire              stk_full   = (depth_q == CNT_W'(STK_DEPTH));
  wire              stk_empty  = (depth_q == '0);
  wire [PTR_W-1:0]  top_idx    = PTR_W'(depth_q - 1'b1);
  wire [PTR_W-1:0]  wr_idx     = PTR_W'(depth_q);
  wire              is_task    = (vec_in[VEC_W-1 -: TASK_TAG_W] == '0);
  wire [LVL_W-1:0]  push_lvl   = (cli_cnt != '0) ? '0 : cur_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STK_DEPTH; i++) begin
        stk_lvl[i] <= '0;
        stk_tsk[i] <= 1'b0;
      end
      depth_q     <= '0;
      cli_cnt     <= '0;
      vec_wait    <= 1'b0;
      pushed_q    <= 1'b0;
      take_irq    <= 1'b0;
      take_lvl    <= '0;
      vec_done    <= 1'b0;
      vec_is_task <= 1'b0;
      vec_task_no <= '0;
      rti_done    <= 1'b0;
      rti_task    <= 1'b0;
      cur_lvl     <= '0;
      err_under   <= 1'b0;
      err_over    <= 1'b0;
    end else begin
      take_irq <= 1'b0;
      vec_done <= 1'b0;
      rti_done <= 1'b0;

      if (cli_cnt != '0) begin
        cli_cnt <= cli_cnt - 1'b1;
        if (cli_cnt == DLY_W'(1)) cur_lvl <= '0;
      end

      if (sei_op) begin
        cur_lvl <= sei_has_lvl ? sei_lvl : LVL_W'(LEVELS);
        cli_cnt <= '0;
      end else if (cli_op) begin
        cli_cnt <= DLY_W'(CLI_DELAY);
      end else if (rti_op) begin
        if (stk_empty) begin
          err_under <= 1'b1;
        end else begin
          cur_lvl  <= stk_lvl[top_idx];
          rti_task <= stk_tsk[top_idx];
          rti_done <= 1'b1;
          depth_q  <= depth_q - 1'b1;
          cli_cnt  <= '0;
        end
      end else if (can_take) begin
        take_irq <= 1'b1;
        take_lvl <= hi_lvl;
        cur_lvl  <= hi_lvl;
        vec_wait <= 1'b1;
        cli_cnt  <= '0;
        if (stk_full) begin
          err_over <= 1'b1;
          pushed_q <= 1'b0;
        end else begin
          stk_lvl[wr_idx] <= push_lvl;
          stk_tsk[wr_idx] <= 1'b0;
          depth_q         <= depth_q + 1'b1;
          pushed_q        <= 1'b1;
        end
      end

      if (vec_wait && vec_ok) begin
        vec_wait    <= 1'b0;
        vec_done    <= 1'b1;
        vec_is_task <= is_task;
        vec_task_no <= vec_in[TASK_W-1:0];
        if (pushed_q) stk_tsk[top_idx] <= is_task;
      end
    end
  end

endmodule

// File: rtl/irq_nest_seq_chk.sv
module irq_nest_seq_chk #(
  parameter int LVL_W     = 2,
  parameter int CNT_W     = 3,
  parameter int STK_DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_end,
  input logic             rti_op,
  input logic             vec_ok,
  input logic             take_irq,
  input logic [LVL_W-1:0] take_lvl,
  input logic             vec_done,
  input logic             rti_done,
  input logic [LVL_W-1:0] cur_lvl,
  input logic             err_under,
  input logic             err_over,
  input logic [CNT_W-1:0] depth_q
);

  AST_TAKE_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (take_lvl > $past(cur_lvl))); // R2

  AST_TAKE_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (cur_lvl == take_lvl)); // R3

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> ($past(insn_end) && !$past(rti_op))); // R3

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq); // R3

  AST_RTI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    rti_done |-> (depth_q == CNT_W'($past(depth_q) - 1'b1))); // R4

  AST_VEC_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_done |-> $past(vec_ok)); // R5

  AST_UNDER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_under) |-> err_under); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= CNT_W'(STK_DEPTH)); // R10

  AST_OVER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_over) |-> err_over); // R10

endmodule

bind irq_nest_seq irq_nest_seq_chk #(
  .LVL_W(LVL_W), .CNT_W(CNT_W), .STK_DEPTH(STK_DEPTH)
) u_chk (.*);

// File: tb/tb_irq_nest_seq.sv
module tb_irq_nest_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] irq_line = '0;
  logic       insn_end = 1'b0;
  logic       sei_op = 1'b0;
  logic       sei_has_lvl = 1'b0;
  logic [1:0] sei_lvl = '0;
  logic       cli_op = 1'b0;
  logic       rti_op = 1'b0;
  logic       vec_ok = 1'b0;
  logic [15:0] vec_in = '0;
  logic       take_irq;
  logic [1:0] take_lvl;
  logic       vec_done;
  logic       vec_is_task;
  logic [8:0] vec_task_no;
  logic       rti_done;
  logic       rti_task;
  logic [1:0] cur_lvl;
  logic       err_under;
  logic       err_over;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_nest_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .insn_end(insn_end),
    .sei_op(sei_op), .sei_has_lvl(sei_has_lvl), .sei_lvl(sei_lvl),
    .cli_op(cli_op), .rti_op(rti_op), .vec_ok(vec_ok), .vec_in(vec_in),
    .take_irq(take_irq), .take_lvl(take_lvl), .vec_done(vec_done),
    .vec_is_task(vec_is_task), .vec_task_no(vec_task_no),
    .rti_done(rti_done), .rti_task(rti_task), .cur_lvl(cur_lvl),
    .err_under(err_under), .err_over(err_over)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_line = '0; insn_end = 1'b0; sei_op = 1'b0;
    cli_op = 1'b0; rti_op = 1'b0; vec_ok = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic take(input logic [2:0] lines);
    irq_line = lines; insn_end = 1'b1;
    step();
    insn_end = 1'b0; irq_line = '0;
  endtask

  task automatic give_vec(input logic [15:0] v);
    vec_in = v; vec_ok = 1'b1;
    step();
    vec_ok = 1'b0;
  endtask

  task automatic do_rti();
    rti_op = 1'b1;
    step();
    rti_op = 1'b0;
  endtask

  task automatic do_sei(input logic has, input logic [1:0] l);
    sei_op = 1'b1; sei_has_lvl = has; sei_lvl = l;
    step();
    sei_op = 1'b0;
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2;
    do_reset();
    chk("R11 reset cur_lvl", cur_lvl, 0);
    chk("R11 reset err_under", err_under, 0);
    chk("R11 reset err_over", err_over, 0);
    chk("R11 reset take_irq", take_irq, 0);

    // R1 R2 R7: level x request pattern sweep
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 8; p++) begin
        int hi;
        hi = (p & 4) ? 3 : (p & 2) ? 2 : (p & 1) ? 1 : 0;
        do_reset();
        if (l != 0) begin
          do_sei(1'b1, 2'(l));
          chk("R7 sei operand level", cur_lvl, l);
        end
        take(3'(p));
        chk("R2 take only above level", take_irq, (hi > l) ? 1 : 0);
        if (hi > l) begin
          chk("R1 highest line wins", take_lvl, hi);
          chk("R3 level follows take", cur_lvl, hi);
          step();
          chk("R3 take is one pulse", take_irq, 0);
        end else begin
          chk("R2 level unchanged", cur_lvl, l);
        end
      end
    end

    do_reset();
    do_sei(1'b0, 2'd0);
    chk("R7 sei without operand", cur_lvl, 3);

    // R3 sampling conditions
    do_reset();
    irq_line = 3'b111; insn_end = 1'b0;
    step();
    chk("R3 no take off boundary", take_irq, 0);
    insn_end = 1'b1; rti_op = 1'b1;
    step();
    rti_op = 1'b0; insn_end = 1'b0;
    chk("R3 no take with strobe", take_irq, 0);
    take(3'b001);
    chk("R3 take level 1", take_lvl, 1);
    take(3'b100);
    chk("R3 no take while vector outstanding", take_irq, 0);
    give_vec(16'h0003);
    take(3'b100);
    chk("R3 take after vector", take_irq, 1);
    chk("R3 take level 3", take_lvl, 3);

    // R5 R6 R4 vector bit sweep
    for (int b = 0; b < 18; b++) begin
      logic [15:0] v;
      int exp_task;
      v = (b < 16) ? 16'(1 << b) : (b == 16) ? 16'h0000 : 16'hFFFF;
      exp_task = ((int'(v) >> 9) == 0) ? 1 : 0;
      do_reset();
      take(3'b010);
      give_vec(v);
      chk("R5 vec_done", vec_done, 1);
      chk("R5 task classify", vec_is_task, exp_task);
      if (exp_task == 1) chk("R5 task number", vec_task_no, int'(v) & 511);
      do_rti();
      chk("R4 rti_done", rti_done, 1);
      chk("R4 level restored", cur_lvl, 0);
      chk("R6 return kind", rti_task, exp_task);
    end

    // R4 R6 nesting
    do_reset();
    take(3'b001); give_vec(16'h0005);
    take(3'b011); give_vec(16'h8000);
    chk("R4 nested level 2", cur_lvl, 2);
    take(3'b111); give_vec(16'h0007);
    chk("R5 nested task number", vec_task_no, 7);
    do_rti();
    chk("R6 pop level 3 kind", rti_task, 1);
    chk("R4 pop to level 2", cur_lvl, 2);
    do_rti();
    chk("R6 pop level 2 kind", rti_task, 0);
    chk("R4 pop to level 1", cur_lvl, 1);
    do_rti();
    chk("R6 pop level 1 kind", rti_task, 1);
    chk("R4 pop to level 0", cur_lvl, 0);

    // R8 delayed clear
    do_reset();
    do_sei(1'b1, 2'd3);
    cli_op = 1'b1;
    step();
    cli_op = 1'b0;
    chk("R8 after cli edge", cur_lvl, 3);
    irq_line = 3'b010; insn_end = 1'b1;
    step();
    chk("R8 held edge 1", cur_lvl, 3);
    chk("R8 no take edge 1", take_irq, 0);
    step();
    chk("R8 held edge 2", cur_lvl, 3);
    step();
    chk("R8 cleared edge 3", cur_lvl, 0);
    chk("R8 no take edge 3", take_irq, 0);
    step();
    insn_end = 1'b0; irq_line = '0;
    chk("R8 take after release", take_irq, 1);
    chk("R8 take level", take_lvl, 2);

    do_reset();
    do_sei(1'b1, 2'd2);
    cli_op = 1'b1;
    step();
    cli_op = 1'b0;
    take(3'b100);
    chk("R8 take during delay", take_irq, 1);
    give_vec(16'h4000);
    do_rti();
    chk("R8 pending clear pushed zero", cur_lvl, 0);

    // R9 underflow
    do_reset();
    do_rti();
    chk("R9 no pop on empty", rti_done, 0);
    chk("R9 underflow flag", err_under, 1);
    do_sei(1'b1, 2'd2);
    do_rti();
    chk("R9 level unchanged", cur_lvl, 2);
    chk("R9 flag sticky", err_under, 1);

    // R10 overflow
    do_reset();
    for (int k = 0; k < 4; k++) begin
      take(3'b001); give_vec(16'(k)); do_sei(1'b1, 2'd0);
    end
    chk("R10 no overflow at four", err_over, 0);
    take(3'b001);
    chk("R10 take still pulses", take_irq, 1);
    chk("R10 overflow flag", err_over, 1);
    give_vec(16'h0009);
    for (int k = 0; k < 4; k++) begin
      do_rti();
      chk("R10 stored pops", rti_done, 1);
    end
    do_rti();
    chk("R10 fifth pop refused", rti_done, 0);
    chk("R10 underflow after four", err_under, 1);
    chk("R10 overflow sticky", err_over, 1);

    do_reset();
    chk("R11 reset clears err_over", err_over, 0);
    chk("R11 reset clears err_under", err_under, 0);
    do_rti();
    chk("R11 stack empty after reset", rti_done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule